// File: doc/BRIEF.md
# Character Wait-Time Counter

This block measures the waiting time between characters on a smart card link. Software builds a 24-bit reload value from three byte-wide staging registers. Writing the most significant byte while the counter is disabled copies all three staged bytes into hold registers at once. Until that top-byte write happens, the hold value stays exactly as it was.

When the enable rises, the counter takes the hold value. It then counts down by one on each elementary-time-unit tick. It halts at zero and raises a timeout flag. The flag stays set until software clears it or a reload happens.

In UART mode, a start bit sent or received reloads the count from the hold registers, so each character restarts the measurement. Outside UART mode, start-bit strobes do nothing. Generating the tick from the card clock is done elsewhere.

Top module: `wt_timer`

## Requirements
- R1: After reset, all staging and hold registers are zero and `timeout` is 0. Raising `cnt_en` with no prior write therefore sets `timeout` at that same enabling edge.
- R2: A write to address 2 (the top byte) while `cnt_en` is 0 loads the hold value with `wr_data*65536 + byte1*256 + byte0`. Here byte0 and byte1 are the values last written to addresses 0 and 1.
- R3: Writes to address 0 or 1 change only the staging bytes. The hold value does not change until the next committing top-byte write.
- R4: A top-byte write while `cnt_en` is 1 changes neither the hold value nor the running count. The new byte is still staged and is used by the next committing write.
- R5: On the clock edge where `cnt_en` is first sampled high, the count loads the hold value N. Ticks in that same cycle are ignored. `timeout` rises at the edge that samples the Nth later `etu_tick`, or at the enabling edge itself when N is 0.
- R6: Once the count reaches zero, further ticks have no effect and `timeout` stays at 1.
- R7: `to_clr` clears `timeout` at the next edge, and the flag then stays 0.
- R8: While `cnt_en` is 0, ticks are ignored and `timeout` does not change. A later rise of `cnt_en` reloads the count from the hold value.
- R9: With `uart_mode`=1 and `cnt_en`=1, a pulse on `tx_start` or `rx_start` reloads the count from the hold value and clears `timeout` (for a nonzero hold).
- R10: If a start-bit reload and a tick fall in the same cycle, the reload wins and that tick is not counted.
- R11: With `uart_mode`=0, `tx_start` and `rx_start` have no effect.
- R12: A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all state |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte select: 0 low, 1 middle, 2 top (commit) |
| wr_data | input | 8 | Write data |
| cnt_en | input | 1 | Counter enable; its rise loads the hold value |
| uart_mode | input | 1 | Enables reload on start bits |
| tx_start | input | 1 | One-cycle pulse: start bit sent |
| rx_start | input | 1 | One-cycle pulse: start bit received |
| etu_tick | input | 1 | Elementary-time-unit tick |
| to_clr | input | 1 | Clears the timeout flag |
| timeout | output | 1 | Sticky timeout flag |

## Verification
`timeout` is a single register, so every effect on it shows up one edge after the input that caused it. The enable edge decides the flag for a zero hold. Otherwise the edge that samples the Nth tick sets it, and the edge after a `to_clr` or a start-bit reload clears it.

The bench drives inputs 2 ns after a rising edge and samples `timeout` 2 ns after the following edge. Each comparison therefore sees exactly one clock of effect. The expected flag value is recomputed every cycle from the number of ticks counted since the last load.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int WT_BYTE_W = 8;
  localparam int WT_NBYTES = 3;
  localparam int WT_CNT_W  = WT_BYTE_W * WT_NBYTES;
  localparam int WT_ADDR_W = $clog2(WT_NBYTES + 1);

  typedef logic [WT_CNT_W-1:0] wt_cnt_t;

  // Merge staged lower bytes with a freshly written top byte.
  function automatic wt_cnt_t wt_commit_value(input wt_cnt_t staged,
                                              input logic [WT_BYTE_W-1:0] top);
    wt_cnt_t v;
    v = staged;
    v[WT_CNT_W-1 -: WT_BYTE_W] = top;
    return v;
  endfunction

  function automatic wt_cnt_t wt_step(input wt_cnt_t c);
    return c - wt_cnt_t'(1);
  endfunction

  function automatic logic wt_last(input wt_cnt_t c);
    return c == wt_cnt_t'(1);
  endfunction

  function automatic logic wt_zero(input wt_cnt_t c);
    return c == '0;
  endfunction
endpackage

// File: rtl/wt_byte_regs.sv
module wt_byte_regs
  import wt_pkg::*;
#(
  parameter int BW = WT_BYTE_W,
  parameter int NB = WT_NBYTES,
  parameter int AW = WT_ADDR_W,
  localparam int CW = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          cnt_en,
  output logic [CW-1:0] hold_val,
  output logic          commit
);
  localparam logic [AW-1:0] TOP_ADDR = AW'(NB - 1);

  logic [CW-1:0] staged;

  for (genvar i = 0; i < NB; i++) begin : g_stage
    logic sel;
    assign sel = wr_en && (wr_addr == AW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) staged[i*BW +: BW] <= '0;
      else if (sel) staged[i*BW +: BW] <= wr_data;
    end
  end

  assign commit = wr_en && (wr_addr == TOP_ADDR) && !cnt_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_val <= '0;
    else if (commit) hold_val <= wt_commit_value(staged, wr_data);
  end

  AST_COMMIT_TAKES_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> hold_val[CW-1 -: BW] == $past(wr_data)); // R2
  AST_HOLD_LOCKED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> $stable(hold_val)); // R4
  AST_LOW_WRITE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != TOP_ADDR) |=> $stable(hold_val)); // R3
endmodule

// File: rtl/wt_event_gate.sv
module wt_event_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic uart_mode,
  input  logic tx_start,
  input  logic rx_start,
  output logic en_rise,
  output logic reload_evt
);
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else en_q <= cnt_en;
  end

  assign en_rise    = cnt_en && !en_q;
  assign reload_evt = cnt_en && uart_mode && (tx_start || rx_start);

  AST_UART_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!uart_mode && !en_rise) |-> !(reload_evt || en_rise)); // R11
endmodule

// File: rtl/wt_down_counter.sv
module wt_down_counter
  import wt_pkg::*;
#(
  parameter int CW = WT_CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          load_evt,
  input  logic          etu_tick,
  input  logic          to_clr,
  input  logic [CW-1:0] hold_val,
  output logic          dec_evt,
  output logic          hit_zero,
  output logic          timeout
);
  logic [CW-1:0] cnt;

  assign dec_evt  = cnt_en && etu_tick && !wt_zero(cnt) && !load_evt;
  assign hit_zero = dec_evt && wt_last(cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      timeout <= 1'b0;
    end else if (load_evt) begin
      cnt     <= hold_val;
      timeout <= wt_zero(hold_val);
    end else begin
      if (dec_evt) cnt <= wt_step(cnt);
      if (hit_zero) timeout <= 1'b1;
      else if (to_clr) timeout <= 1'b0;
    end
  end

  AST_LOAD_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt == $past(hold_val)); // R5
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_evt |=> cnt == $past(cnt) - 1'b1); // R5
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !load_evt) |=> cnt == '0); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !to_clr && !load_evt) |=> timeout); // R6
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt)); // R8
  AST_RELOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && etu_tick) |=> cnt == $past(hold_val)); // R10
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (to_clr && !hit_zero && !load_evt) |=> !timeout); // R7
endmodule

// File: rtl/wt_timer.sv
module wt_timer
  import wt_pkg::*;
#(
  parameter int BW = WT_BYTE_W,
  parameter int NB = WT_NBYTES,
  localparam int AW = $clog2(NB + 1),
  localparam int CW = BW * NB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [BW-1:0] wr_data,
  input  logic          cnt_en,
  input  logic          uart_mode,
  input  logic          tx_start,
  input  logic          rx_start,
  input  logic          etu_tick,
  input  logic          to_clr,
  output logic          timeout
);
  logic [CW-1:0] hold_val;
  logic          commit;
  logic          en_rise;
  logic          reload_evt;
  logic          load_evt;
  logic          dec_evt;
  logic          hit_zero;

  wt_byte_regs #(.BW(BW), .NB(NB), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_en(cnt_en), .hold_val(hold_val), .commit(commit)
  );

  wt_event_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .uart_mode(uart_mode),
    .tx_start(tx_start), .rx_start(rx_start),
    .en_rise(en_rise), .reload_evt(reload_evt)
  );

  assign load_evt = en_rise || reload_evt;

  wt_down_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_evt(load_evt),
    .etu_tick(etu_tick), .to_clr(to_clr), .hold_val(hold_val),
    .dec_evt(dec_evt), .hit_zero(hit_zero), .timeout(timeout)
  );

  AST_NO_COMMIT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !cnt_en); // R4
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(timeout) || $past(to_clr)); // R8
endmodule

// File: tb/tb_wt_timer.sv
module tb_wt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       cnt_en = 1'b0;
  logic       uart_mode = 1'b0;
  logic       tx_start = 1'b0;
  logic       rx_start = 1'b0;
  logic       etu_tick = 1'b0;
  logic       to_clr = 1'b0;
  logic       timeout;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wt_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cnt_en(cnt_en), .uart_mode(uart_mode),
    .tx_start(tx_start), .rx_start(rx_start), .etu_tick(etu_tick),
    .to_clr(to_clr), .timeout(timeout)
  );

  function automatic int join_bytes(int b2, int b1, int b0);
    return b2 * 65536 + b1 * 256 + b0;
  endfunction

  function automatic bit flag_due(int ticks, int n);
    return ticks >= n;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(bit act, bit exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: timeout=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic load_value(int v);
    wr(0, v & 255);
    wr(1, (v >> 8) & 255);
    wr(2, (v >> 16) & 255);
  endtask

  // Enable and count; checks flag every cycle for `extra` cycles past N ticks.
  task automatic measure(int n, int dens, int extra, string tag);
    int ticks = 0;
    int over = 0;
    etu_tick = 1'b0; cnt_en = 1'b1;
    cyc();
    chk(timeout, n == 0, tag);
    while (over < extra) begin
      etu_tick = ($urandom_range(99) < dens);
      cyc();
      if (etu_tick) ticks++;
      chk(timeout, flag_due(ticks, n), tag);
      if (ticks >= n) over++;
    end
    etu_tick = 1'b0;
  endtask

  task automatic stop();
    cnt_en = 1'b0; etu_tick = 1'b0;
    cyc();
  endtask

  task automatic ticks_n(int k);
    for (int i = 0; i < k; i++) begin
      etu_tick = 1'b1; cyc();
    end
    etu_tick = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cyc();
    chk(timeout, 1'b0, "R1 reset flag");
    measure(0, 50, 2, "R1 zero hold after reset");
    stop();

    load_value(5);
    measure(5, 60, 3, "R2 commit small");
    stop();

    wr(0, 9);
    measure(5, 60, 2, "R3 low write held back");
    stop();
    wr(2, 0);
    measure(9, 60, 2, "R3 commit picks staged byte");
    stop();

    load_value(6);
    cnt_en = 1'b1; cyc();
    wr(2, 1);
    ticks_n(5);
    chk(timeout, 1'b0, "R4 running count kept");
    ticks_n(1);
    chk(timeout, 1'b1, "R4 running count kept");
    stop();
    measure(6, 70, 2, "R4 hold unchanged");
    stop();

    ticks_n(4);
    chk(timeout, 1'b1, "R8 flag steady while off");
    to_clr = 1'b1; cyc(); to_clr = 1'b0;
    chk(timeout, 1'b0, "R7 clear");
    ticks_n(3);
    chk(timeout, 1'b0, "R7 stays clear");

    load_value(3);
    cnt_en = 1'b1; cyc();
    ticks_n(2);
    cnt_en = 1'b0; cyc();
    ticks_n(6);
    chk(timeout, 1'b0, "R8 ticks ignored while off");
    measure(3, 100, 3, "R8 re-enable reloads");

    ticks_n(10);
    chk(timeout, 1'b1, "R6 sticky at zero");
    stop();

    load_value(5);
    uart_mode = 1'b1;
    cnt_en = 1'b1; cyc();
    ticks_n(4);
    rx_start = 1'b1; cyc(); rx_start = 1'b0;
    ticks_n(4);
    chk(timeout, 1'b0, "R9 rx reload");
    ticks_n(1);
    chk(timeout, 1'b1, "R9 rx reload");
    tx_start = 1'b1; cyc(); tx_start = 1'b0;
    chk(timeout, 1'b0, "R9 tx reload clears flag");
    ticks_n(3);
    tx_start = 1'b1; etu_tick = 1'b1; cyc(); tx_start = 1'b0;
    ticks_n(4);
    chk(timeout, 1'b0, "R10 reload beats tick");
    ticks_n(1);
    chk(timeout, 1'b1, "R10 reload beats tick");
    stop();

    uart_mode = 1'b0;
    cnt_en = 1'b1; cyc();
    ticks_n(3);
    rx_start = 1'b1; tx_start = 1'b1; etu_tick = 1'b1; cyc();
    rx_start = 1'b0; tx_start = 1'b0; etu_tick = 1'b0;
    chk(timeout, 1'b0, "R11 strobes ignored");
    ticks_n(1);
    chk(timeout, 1'b1, "R11 strobes ignored");
    stop();

    wr(0, 7); wr(1, 0);
    wr(3, 200);
    wr(2, 0);
    measure(7, 80, 2, "R12 address 3 inert");
    stop();

    for (int it = 0; it < 24; it++) begin
      int b0 = $urandom_range(255);
      int b1 = $urandom_range(1);
      if ($urandom_range(1)) begin wr(1, b1); wr(0, b0); end
      else begin wr(0, b0); wr(1, b1); end
      wr(2, 0);
      measure(join_bytes(0, b1, b0), 40 + $urandom_range(60), 2, "R5 random reload");
      stop();
    end

    load_value(join_bytes(1, 0, 0));
    measure(join_bytes(1, 0, 0), 100, 2, "R2 top byte weight");
    stop();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule